// File: doc/BRIEF.md
# Mode-Aware Free-Running Clock Output Generator

This block derives two free-running clock outputs from a fast reference clock running at four times the bus clock rate, so one bus period is `4*DR_HALF` reference cycles with the default `DR_HALF` of 1. The first output, the double-rate clock, toggles at twice the bus rate. An active-high disable bit can stop it. The second output, the divided clock, runs at the bus rate divided by a factor of 1 to `2**DIV_W`. A select field in a small control register chooses the factor. Both outputs are registers in the reference clock domain.

An emulation-mode input overrides the programmed settings. While it is high, the divided clock runs undivided at the bus rate and the double-rate clock runs whatever the disable bit holds. Every enable, disable and ratio change takes effect only at a clean phase boundary, so neither output ever produces a shortened pulse.

Top module: `fclk_outputs`

## Requirements
- R1: After reset the select field is 0 and the disable bit is 0. The divided clock runs at the bus rate with high and low each half a bus period, and the double-rate clock runs.
- R2: While enabled, the double-rate clock is high for `DR_HALF` reference cycles and low for `DR_HALF` cycles, which is half a bus period in total.
- R3: Outside emulation, with the disable bit at 1, the double-rate clock settles to and holds a static low within `2*DR_HALF` cycles.
- R4: Every high pulse of the double-rate clock lasts exactly `DR_HALF` cycles, including pulses around a disable or a re-enable.
- R5: Select value k sets the divided clock period to k+1 bus periods (00 = 1, 01 = 2, 10 = 3, 11 = 4).
- R6: For factor 1 the divided clock is high for half a bus period. For an even factor N it is high for N/2 bus periods. For an odd factor N above 1 it is high for (N-1)/2 bus periods, so for N=3 it is high for one bus period and low for two.
- R7: While emulation is asserted, the divided clock runs at the bus rate whatever the select field holds.
- R8: While emulation is asserted, the double-rate clock runs whatever the disable bit holds.
- R9: A new select value takes effect only at the end of the divided period in progress, which finishes with its old high and low times. No divided-clock phase is ever shorter than half a bus period.
- R10: The register fields are loaded only in a cycle with `cfg_we` high. Changes to `cfg_div` or `cfg_dr_off` at other times have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_mode | input | 1 | High while the chip operates in emulation |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_dr_off | input | 1 | Double-rate clock disable value (1 = off) |
| cfg_div | input | DIV_W | Divider select value, factor = value + 1 |
| dr_clk_o | output | 1 | Double-rate free-running clock |
| div_clk_o | output | 1 | Divided free-running clock |

## Verification
The divided clock is measured from rising edge to rising edge at every select value. The measured high time and period separate the four ratios and also expose a wrong duty split for odd factors. A select change is written in the middle of a long high phase, which shows whether the running period finishes with its old lengths or is cut short. Emulation is entered with the clock disabled and the largest factor programmed, which separates a true override from the programmed settings. A write with the strobe low, followed by a check that the old ratio persists, shows whether the fields are gated by the strobe.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

   // High time of the divided clock, in half-bus-period units, for a given factor
   function automatic int unsigned high_halves(input int unsigned factor);
      if (factor <= 1) return 1;
      return (factor / 2) * 2;
   endfunction

   // Full period of the divided clock, in half-bus-period units
   function automatic int unsigned period_halves(input int unsigned factor);
      return 2 * factor;
   endfunction

endpackage

// File: rtl/fclk_cfg_reg.sv
module fclk_cfg_reg #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             dr_off_in,
   input  logic [DIV_W-1:0] div_in,
   output logic             dr_off_q,
   output logic [DIV_W-1:0] div_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dr_off_q <= 1'b0;
         div_q    <= '0;
      end else if (we) begin
         dr_off_q <= dr_off_in;
         div_q    <= div_in;
      end
   end

endmodule

// File: rtl/fclk_tick_gen.sv
module fclk_tick_gen #(
   parameter int DR_HALF = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic dr_tick,
   output logic half_tick
);

   localparam int HALF_BUS = 2 * DR_HALF;
   localparam int CW       = (HALF_BUS > 2) ? $clog2(HALF_BUS) : 1;

   generate
      if (DR_HALF == 1) begin : g_every
         logic ph;
         always_ff @(posedge clk) begin
            if (!rst_n) ph <= 1'b0;
            else        ph <= ~ph;
         end
         assign dr_tick   = 1'b1;
         assign half_tick = ph;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                           cnt <= '0;
            else if (cnt == CW'(HALF_BUS - 1))    cnt <= '0;
            else                                  cnt <= cnt + CW'(1);
         end
         assign half_tick = (cnt == CW'(HALF_BUS - 1));
         assign dr_tick   = half_tick || (cnt == CW'(DR_HALF - 1));
      end
   endgenerate

endmodule

// File: rtl/fclk_dr_out.sv
module fclk_dr_out (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   output logic clk_o
);

   // The enable is sampled only where a high phase would start, so a
   // running pulse always completes and a new one always starts whole.
   always_ff @(posedge clk) begin
      if (!rst_n)      clk_o <= 1'b0;
      else if (tick)   clk_o <= clk_o ? 1'b0 : en;
   end

endmodule

// File: rtl/fclk_div_out.sv
module fclk_div_out #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_tick,
   input  logic [DIV_W-1:0] div_sel,
   output logic             clk_o
);

   localparam int PW = DIV_W + 2;

   logic [DIV_W-1:0] sel_act;
   logic [PW-1:0]    ph;
   logic [PW-1:0]    last_ph;
   logic [PW-1:0]    nxt_ph;
   logic [PW-1:0]    nxt_hi;
   logic [DIV_W-1:0] nxt_sel;
   logic             wrap;

   always_comb begin
      last_ph = PW'(fclk_pkg::period_halves(32'(sel_act) + 1) - 1);
      wrap    = (ph == last_ph);
      nxt_sel = wrap ? div_sel : sel_act;
      nxt_ph  = wrap ? '0 : ph + PW'(1);
      nxt_hi  = PW'(fclk_pkg::high_halves(32'(nxt_sel) + 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_act <= '0;
         ph      <= PW'(1);
         clk_o   <= 1'b0;
      end else if (half_tick) begin
         sel_act <= nxt_sel;
         ph      <= nxt_ph;
         clk_o   <= (nxt_ph < nxt_hi);
      end
   end

endmodule

// File: rtl/fclk_outputs.sv
module fclk_outputs #(
   parameter int DR_HALF = 1,
   parameter int DIV_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             emu_mode,
   input  logic             cfg_we,
   input  logic             cfg_dr_off,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             dr_clk_o,
   output logic             div_clk_o
);

   generate
      if (DR_HALF < 1) begin : g_bad_half
         $error("fclk_outputs: DR_HALF must be at least 1");
      end
      if (DIV_W < 1 || DIV_W > 6) begin : g_bad_div
         $error("fclk_outputs: DIV_W must lie in 1..6");
      end
   endgenerate

   logic             dr_off_q;
   logic [DIV_W-1:0] div_q;
   logic             dr_tick;
   logic             half_tick;
   logic             dr_en;
   logic [DIV_W-1:0] div_eff;

   fclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .dr_off_in (cfg_dr_off),
      .div_in    (cfg_div),
      .dr_off_q  (dr_off_q),
      .div_q     (div_q)
   );

   fclk_tick_gen #(.DR_HALF(DR_HALF)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .dr_tick   (dr_tick),
      .half_tick (half_tick)
   );

   // Emulation override: double-rate forced on, divider forced to bypass
   assign dr_en   = emu_mode | ~dr_off_q;
   assign div_eff = emu_mode ? '0 : div_q;

   fclk_dr_out u_dr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (dr_tick),
      .en    (dr_en),
      .clk_o (dr_clk_o)
   );

   fclk_div_out #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .div_sel   (div_eff),
      .clk_o     (div_clk_o)
   );

endmodule

// File: rtl/fclk_outputs_chk.sv
module fclk_outputs_chk #(
   parameter int DR_HALF = 1,
   parameter int DIV_W   = 2
) (
   input logic clk,
   input logic rst_n,
   input logic emu_mode,
   input logic dr_off_q,
   input logic dr_clk_o,
   input logic div_clk_o
);

   localparam int EMU_SETTLE = ((2 ** DIV_W) + 2) * 4 * DR_HALF;

   logic        dr_prev, div_prev, div_seen;
   logic [15:0] dr_run, div_run;
   logic [31:0] emu_age, off_age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dr_prev  <= 1'b0;
         div_prev <= 1'b0;
         div_seen <= 1'b0;
         dr_run   <= '0;
         div_run  <= '0;
         emu_age  <= '0;
         off_age  <= '0;
      end else begin
         dr_prev  <= dr_clk_o;
         div_prev <= div_clk_o;
         if (div_clk_o != div_prev) div_seen <= 1'b1;
         dr_run   <= (dr_clk_o != dr_prev) ? 16'd1 :
                     ((dr_run == 16'hFFFF) ? dr_run : dr_run + 16'd1);
         div_run  <= (div_clk_o != div_prev) ? 16'd1 :
                     ((div_run == 16'hFFFF) ? div_run : div_run + 16'd1);
         emu_age  <= !emu_mode ? '0 :
                     ((emu_age == 32'hFFFF_FFFF) ? emu_age : emu_age + 32'd1);
         off_age  <= (emu_mode || !dr_off_q) ? '0 :
                     ((off_age == 32'hFFFF_FFFF) ? off_age : off_age + 32'd1);
      end
   end

   // R4 (and R2): each double-rate high pulse is exactly DR_HALF cycles
   dr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_prev && !dr_clk_o) |-> (dr_run == 16'(DR_HALF)));

   // R9
   div_min_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_seen && (div_clk_o != div_prev)) |-> (div_run >= 16'(2 * DR_HALF)));

   // R3
   dr_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_age >= 32'(2 * DR_HALF)) |-> !dr_clk_o);

   // R8
   emu_dr_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emu_age >= 32'(4 * DR_HALF) && (dr_clk_o != dr_prev)) |-> (dr_run == 16'(DR_HALF)));

   // R7
   emu_div_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emu_age >= 32'(EMU_SETTLE) && (div_clk_o != div_prev)) |-> (div_run == 16'(2 * DR_HALF)));

endmodule

bind fclk_outputs fclk_outputs_chk #(.DR_HALF(DR_HALF), .DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .emu_mode  (emu_mode),
   .dr_off_q  (dr_off_q),
   .dr_clk_o  (dr_clk_o),
   .div_clk_o (div_clk_o)
);

// File: tb/fclk_outputs_test.sv
`timescale 1ns/1ps
module fclk_outputs_test;

   localparam int DR_HALF = 1;
   localparam int DIV_W   = 2;
   localparam int BUS     = 4 * DR_HALF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             emu_mode = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_dr_off = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             dr_clk_o, div_clk_o;

   int checks = 0;
   int errors = 0;

   int    dq_hi[$], dq_per[$];
   string dq_tag[$];
   int    rq_hi[$], rq_per[$];
   string rq_tag[$];

   always #2.5 clk = ~clk;

   fclk_outputs #(.DR_HALF(DR_HALF), .DIV_W(DIV_W)) uut (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .cfg_we(cfg_we),
      .cfg_dr_off(cfg_dr_off), .cfg_div(cfg_div),
      .dr_clk_o(dr_clk_o), .div_clk_o(div_clk_o)
   );

   // Monitor: measures each period from rising edge to rising edge
   int d_hi, d_per, r_hi, r_per;
   logic d_prev, r_prev, d_seen, r_seen;
   always @(negedge clk) begin
      if (!rst_n) begin
         d_hi = 0; d_per = 0; d_prev = 1'b0; d_seen = 1'b0;
         r_hi = 0; r_per = 0; r_prev = 1'b0; r_seen = 1'b0;
      end else begin
         if (div_clk_o && !d_prev) begin
            if (d_seen && dq_hi.size() > 0) begin
               checks++;
               if (d_hi != dq_hi[0] || d_per != dq_per[0]) begin
                  errors++;
                  $display("FAIL %s: divided clock high %0d period %0d, expected high %0d period %0d",
                           dq_tag[0], d_hi, d_per, dq_hi[0], dq_per[0]);
               end
               void'(dq_hi.pop_front()); void'(dq_per.pop_front()); void'(dq_tag.pop_front());
            end
            d_seen = 1'b1; d_hi = 0; d_per = 0;
         end
         d_per++; if (div_clk_o) d_hi++; d_prev = div_clk_o;

         if (dr_clk_o && !r_prev) begin
            if (r_seen && rq_hi.size() > 0) begin
               checks++;
               if (r_hi != rq_hi[0] || r_per != rq_per[0]) begin
                  errors++;
                  $display("FAIL %s: double-rate clock high %0d period %0d, expected high %0d period %0d",
                           rq_tag[0], r_hi, r_per, rq_hi[0], rq_per[0]);
               end
               void'(rq_hi.pop_front()); void'(rq_per.pop_front()); void'(rq_tag.pop_front());
            end
            r_seen = 1'b1; r_hi = 0; r_per = 0;
         end
         r_per++; if (dr_clk_o) r_hi++; r_prev = dr_clk_o;
      end
   end

   task automatic write_cfg(input logic off, input logic [DIV_W-1:0] div);
      @(negedge clk);
      cfg_we = 1'b1; cfg_dr_off = off; cfg_div = div;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_div(input int n, input int hi, input int per, input string tag);
      repeat (40) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         dq_hi.push_back(hi); dq_per.push_back(per); dq_tag.push_back(tag);
      end
      while (dq_hi.size() != 0) @(negedge clk);
   endtask

   task automatic expect_dr(input int n, input int hi, input int per, input string tag);
      repeat (40) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rq_hi.push_back(hi); rq_per.push_back(per); rq_tag.push_back(tag);
      end
      while (rq_hi.size() != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs held low in reset
      checks++;
      if (dr_clk_o !== 1'b0 || div_clk_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset outputs %b%b, expected 00", dr_clk_o, div_clk_o);
      end
      rst_n = 1'b1;

      // R1: defaults after reset, R2: double-rate timing
      expect_div(3, BUS / 2, BUS, "R1");
      expect_dr(3, DR_HALF, 2 * DR_HALF, "R2");

      // R5 / R6: every programmed ratio
      write_cfg(1'b0, 2'd1); expect_div(3, BUS, 2 * BUS, "R5 div2");
      write_cfg(1'b0, 2'd2); expect_div(3, BUS, 3 * BUS, "R6 div3");
      write_cfg(1'b0, 2'd3); expect_div(3, 2 * BUS, 4 * BUS, "R5 div4");

      // R9: change select mid high phase; old period must complete
      repeat (40) @(negedge clk);
      begin
         logic p;
         p = div_clk_o;
         forever begin
            @(negedge clk);
            if (div_clk_o && !p) break;
            p = div_clk_o;
         end
      end
      repeat (2) @(negedge clk);
      dq_hi.push_back(2 * BUS); dq_per.push_back(4 * BUS); dq_tag.push_back("R9 old");
      dq_hi.push_back(BUS / 2); dq_per.push_back(BUS);     dq_tag.push_back("R9 new");
      dq_hi.push_back(BUS / 2); dq_per.push_back(BUS);     dq_tag.push_back("R9 new");
      write_cfg(1'b0, 2'd0);
      while (dq_hi.size() != 0) @(negedge clk);

      // R10: fields change without strobe -> no effect
      write_cfg(1'b0, 2'd1);
      @(negedge clk);
      cfg_div = 2'd3; cfg_dr_off = 1'b1;
      expect_div(3, BUS, 2 * BUS, "R10");
      expect_dr(2, DR_HALF, 2 * DR_HALF, "R10");

      // R3: disabled double-rate clock holds low
      write_cfg(1'b1, 2'd3);
      repeat (10) @(negedge clk);
      begin
         int highs;
         highs = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dr_clk_o) highs++;
         end
         checks++;
         if (highs != 0) begin
            errors++;
            $display("FAIL R3: disabled clock high samples %0d, expected 0", highs);
         end
      end

      // R7 / R8: emulation overrides both settings
      emu_mode = 1'b1;
      expect_dr(4, DR_HALF, 2 * DR_HALF, "R8");
      expect_div(4, BUS / 2, BUS, "R7");

      // R4: leave emulation, re-enable, pulses whole
      emu_mode = 1'b0;
      write_cfg(1'b0, 2'd3);
      expect_dr(3, DR_HALF, 2 * DR_HALF, "R4");
      expect_div(2, 2 * BUS, 4 * BUS, "R7 exit");

      summary();
      $finish;
   end

endmodule